// File: doc/BRIEF.md
# Fracturable LUT Arithmetic Logic Element

This block is one logic element of a programmable fabric. It holds a 64-entry truth table and a small set of mode bits, both written through a configuration port. From six general inputs the element evaluates either a single 6-input function, or two 5-input functions that share their five low inputs. Behind the table sits a hardened one-bit full adder. Dedicated carry-in and carry-out ports chain neighbouring elements into a ripple adder, one bit per element.

The adder operands come from one of two sources. In the split arithmetic mode they are the two 5-input function values. In the pin arithmetic mode one operand is the full 6-input value and the other is a direct input pin. In logic mode the adder operands are forced to zero. An output-select bit chooses whether the element result is the sum or the 6-input table value. A final flip-flop can register that result. It has a clock enable and a reset to zero, and a bypass bit chooses between the registered value and the combinational value.

Top module: `fle_top`

## Requirements
- R1: While `rst_n` is low, the stored configuration (table, mode, output select, bypass) and the output flip-flop clear to zero. With the cleared bypass bit, `elem_out` therefore reads 0.
- R2: On a rising clock edge with `cfg_we` high, `cfg_table`, `cfg_mode`, `cfg_sel_sum` and `cfg_bypass` are stored. With `cfg_we` low, those inputs have no effect on any output.
- R3: In mode 0 (logic), the element value with output select 0 is table bit `lut_in` (unsigned index 0..63). Both adder operands are 0, so `carry_out` is 0.
- R4: In mode 1 (split arithmetic), operand A is table bit `lut_in[4:0]` and operand B is table bit `32 + lut_in[4:0]`. `lut_in[5]` does not affect the adder.
- R5: In mode 2 (pin arithmetic), operand A is table bit `lut_in` and operand B is `pin_b`.
- R6: The sum is the parity of A, B and `carry_in`. `carry_out` is 1 when at least two of them are 1. Both are combinational.
- R7: With output select 1 the element value is the sum; with 0 it is table bit `lut_in`. Mode 3 behaves as mode 0.
- R8: With bypass 1, `elem_out` follows the element value in the same cycle. With bypass 0, `elem_out` shows the flip-flop, which loads the element value on a rising edge where `ff_en` is high.
- R9: On a rising edge with `ff_en` low, the flip-flop keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_table | input | 64 | Truth table to store |
| cfg_mode | input | 2 | Mode: 0 logic, 1 split arithmetic, 2 pin arithmetic, 3 as 0 |
| cfg_sel_sum | input | 1 | 1: element value is the sum; 0: the 6-input table value |
| cfg_bypass | input | 1 | 1: combinational output; 0: registered output |
| lut_in | input | 6 | General table inputs |
| pin_b | input | 1 | Direct operand B in pin arithmetic mode |
| ff_en | input | 1 | Flip-flop clock enable |
| carry_in | input | 1 | Carry from the previous element |
| carry_out | output | 1 | Carry to the next element |
| elem_out | output | 1 | Element output |

## Verification
The bench builds the element with its default of six table inputs, giving a 64-bit table. All 64 index values are reachable in a short sweep. This lets the bench exercise every table bit under both the whole-table indexing and the split indexing. It also shows that the top index bit cannot change the adder in split mode, and it drives every carry-in and operand combination against both output selections and both output paths.

// File: rtl/fle_pkg.sv
package fle_pkg;

  typedef enum logic [1:0] {
    MODE_LOGIC = 2'd0,
    MODE_SPLIT = 2'd1,
    MODE_PIN   = 2'd2,
    MODE_SPARE = 2'd3
  } mode_e;

  typedef struct packed {
    mode_e mode;
    logic  sel_sum;
    logic  bypass;
  } ctrl_t;

  function automatic logic fa_sum(input logic a, input logic b, input logic c);
    return a ^ b ^ c;
  endfunction

  function automatic logic fa_carry(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

endpackage

// File: rtl/fle_lut.sv
module fle_lut #(
  parameter int K = 6
) (
  input  logic [(1<<K)-1:0] table_bits,
  input  logic [K-1:0]      sel,
  output logic              full_val,
  output logic              low_val,
  output logic              high_val
);
  localparam int HALF = (1 << K) / 2;

  logic [HALF-1:0] low_half;
  logic [HALF-1:0] high_half;

  assign low_half  = table_bits[HALF-1:0];
  assign high_half = table_bits[2*HALF-1:HALF];

  assign full_val = table_bits[sel];
  assign low_val  = low_half[sel[K-2:0]];
  assign high_val = high_half[sel[K-2:0]];
endmodule

// File: rtl/fle_adder.sv
module fle_adder
  import fle_pkg::*;
(
  input  mode_e mode,
  input  logic  full_val,
  input  logic  low_val,
  input  logic  high_val,
  input  logic  pin_b,
  input  logic  carry_in,
  output logic  op_a,
  output logic  op_b,
  output logic  sum,
  output logic  carry_out
);
  always_comb begin
    case (mode)
      MODE_SPLIT: begin
        op_a = low_val;
        op_b = high_val;
      end
      MODE_PIN: begin
        op_a = full_val;
        op_b = pin_b;
      end
      default: begin
        op_a = 1'b0;
        op_b = 1'b0;
      end
    endcase
  end

  assign sum       = fa_sum(op_a, op_b, carry_in);
  assign carry_out = fa_carry(op_a, op_b, carry_in);
endmodule

// File: rtl/fle_outreg.sv
module fle_outreg (
  input  logic clk,
  input  logic rst_n,
  input  logic ff_en,
  input  logic bypass,
  input  logic d,
  output logic q,
  output logic y
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= 1'b0;
    else if (ff_en) q <= d;
  end

  assign y = bypass ? d : q;
endmodule

// File: rtl/fle_top.sv
module fle_top
  import fle_pkg::*;
#(
  parameter int K = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [(1<<K)-1:0] cfg_table,
  input  logic [1:0]        cfg_mode,
  input  logic              cfg_sel_sum,
  input  logic              cfg_bypass,
  input  logic [K-1:0]      lut_in,
  input  logic              pin_b,
  input  logic              ff_en,
  input  logic              carry_in,
  output logic              carry_out,
  output logic              elem_out
);
  localparam int TW = 1 << K;

  logic [TW-1:0] tbl_q;
  ctrl_t         ctrl_q;
  logic          full_val, low_val, high_val;
  logic          op_a, op_b, sum;
  logic          comb_val, q_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tbl_q  <= '0;
      ctrl_q <= '0;
    end else if (cfg_we) begin
      tbl_q  <= cfg_table;
      ctrl_q <= '{mode: mode_e'(cfg_mode), sel_sum: cfg_sel_sum, bypass: cfg_bypass};
    end
  end

  fle_lut #(.K(K)) u_lut (
    .table_bits(tbl_q),
    .sel       (lut_in),
    .full_val  (full_val),
    .low_val   (low_val),
    .high_val  (high_val)
  );

  fle_adder u_add (
    .mode     (ctrl_q.mode),
    .full_val (full_val),
    .low_val  (low_val),
    .high_val (high_val),
    .pin_b    (pin_b),
    .carry_in (carry_in),
    .op_a     (op_a),
    .op_b     (op_b),
    .sum      (sum),
    .carry_out(carry_out)
  );

  assign comb_val = ctrl_q.sel_sum ? sum : full_val;

  fle_outreg u_out (
    .clk   (clk),
    .rst_n (rst_n),
    .ff_en (ff_en),
    .bypass(ctrl_q.bypass),
    .d     (comb_val),
    .q     (q_val),
    .y     (elem_out)
  );
endmodule

// File: rtl/fle_checker.sv
module fle_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode,
  input logic       bypass,
  input logic       ff_en,
  input logic       op_a,
  input logic       op_b,
  input logic       carry_in,
  input logic       carry_out,
  input logic       comb_val,
  input logic       q_val,
  input logic       elem_out
);
  logic past_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  assert_logic_ops_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0 || mode == 2'd3) |-> (!op_a && !op_b));
  assert_carry_gen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_a && op_b) |-> carry_out);
  assert_carry_kill_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_a && !op_b) |-> !carry_out);
  assert_carry_prop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_a != op_b) |-> (carry_out == carry_in));
  assert_bypass_comb_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bypass |-> (elem_out == comb_val));
  assert_ff_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && ff_en) |=> (q_val == $past(comb_val)));
  assert_ff_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !ff_en) |=> $stable(q_val));
endmodule

bind fle_top fle_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .mode     (ctrl_q.mode),
  .bypass   (ctrl_q.bypass),
  .ff_en    (ff_en),
  .op_a     (op_a),
  .op_b     (op_b),
  .carry_in (carry_in),
  .carry_out(carry_out),
  .comb_val (comb_val),
  .q_val    (q_val),
  .elem_out (elem_out)
);

// File: tb/sim_fle_top.sv
`timescale 1ns/1ps
module sim_fle_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [63:0] cfg_table = '0;
  logic [1:0]  cfg_mode = '0;
  logic        cfg_sel_sum = 1'b0;
  logic        cfg_bypass = 1'b0;
  logic [5:0]  lut_in = '0;
  logic        pin_b = 1'b0;
  logic        ff_en = 1'b0;
  logic        carry_in = 1'b0;
  logic        carry_out, elem_out;

  always #5 clk = ~clk;

  fle_top u0 (.*);

  int tests = 0;
  int fails = 0;
  bit done = 0;

  // reference state
  logic [63:0] m_tbl = '0;
  int          m_mode = 0;
  bit          m_sel = 0, m_byp = 0, m_q = 0;

  task automatic check(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input bit we, input logic [63:0] tb, input int md, input bit ss,
                      input bit bp, input int li, input bit pb, input bit en,
                      input bit ci, input string tag);
    int a, b, tot, full, s, co, comb, eo;
    @(negedge clk);
    cfg_we = we; cfg_table = tb; cfg_mode = md[1:0]; cfg_sel_sum = ss;
    cfg_bypass = bp; lut_in = li[5:0]; pin_b = pb; ff_en = en; carry_in = ci;
    #2;
    full = int'(m_tbl[li % 64]);
    if (m_mode == 1) begin
      a = int'(m_tbl[li % 32]); b = int'(m_tbl[32 + li % 32]);
    end else if (m_mode == 2) begin
      a = full; b = int'(pb);
    end else begin
      a = 0; b = 0;
    end
    tot = a + b + int'(ci);
    s = tot % 2;
    co = (tot >= 2) ? 1 : 0;
    comb = m_sel ? s : full;
    eo = m_byp ? comb : int'(m_q);
    check({tag, " carry"}, int'(carry_out), co);
    check({tag, " out"}, int'(elem_out), eo);
    @(posedge clk);
    if (en) m_q = comb[0];
    if (we) begin
      m_tbl = tb; m_mode = md; m_sel = ss; m_byp = bp;
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [63:0] pat;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset out", int'(elem_out), 0);
    check("R1 reset carry", int'(carry_out), 0);
    @(negedge clk); rst_n = 1'b1;

    // R1: cleared config: logic mode, table zero, registered path
    step(0, '1, 2, 1, 1, 63, 1, 1, 1, "R1 R2 cleared");
    step(0, '1, 1, 1, 1, 5, 1, 0, 1, "R2 ignored");

    // R3: logic mode, bypass, whole-table index
    pat = 64'h8F3C_0000_FFFF_A5A5;
    step(1, pat, 0, 0, 1, 0, 0, 0, 0, "R2 load");
    for (int i = 0; i < 64; i++)
      step(0, 64'h0, 2, 1, 0, i, i[0], 0, i[1], "R3 R2 sweep");

    // mode 3 and sum select in logic mode: sum equals carry_in
    step(1, pat, 3, 1, 1, 0, 0, 0, 0, "R7 load");
    for (int i = 0; i < 16; i++)
      step(0, '0, 0, 0, 0, i * 4, 1, 0, i[0], "R7 spare mode");

    // R4: split arithmetic, both halves, top bit ignored
    pat = {32'hCCCC_CCCC, 32'hAAAA_AAAA};
    step(1, pat, 1, 1, 1, 0, 0, 0, 0, "R4 load");
    for (int i = 0; i < 64; i++)
      for (int c = 0; c < 2; c++)
        step(0, '0, 0, 0, 0, i, 1, 0, c[0], "R4 R6 split");

    // R5: pin arithmetic, LUT value select then sum select
    pat = 64'hF0F0_1234_9876_0FF0;
    step(1, pat, 2, 0, 1, 0, 0, 0, 0, "R5 load");
    for (int i = 0; i < 32; i++)
      step(0, '0, 0, 0, 0, i * 2 + 1, i[1], 0, i[2], "R5 R7 lutsel");
    step(1, pat, 2, 1, 1, 0, 0, 0, 0, "R5 load sum");
    for (int i = 0; i < 64; i++)
      for (int p = 0; p < 4; p++)
        step(0, '0, 1, 0, 0, i, p[0], 0, p[1], "R5 R6 pin");

    // R8 R9: registered path with enable patterns
    step(1, pat, 2, 1, 0, 0, 0, 0, 0, "R8 load reg");
    for (int i = 0; i < 400; i++)
      step(0, '0, 0, 0, 0, $urandom % 64, 1'($urandom), 1'($urandom),
           1'($urandom), "R8 R9 reg");

    // mixed random, including config writes
    for (int i = 0; i < 2000; i++)
      step(($urandom % 8) == 0, {$urandom, $urandom}, $urandom % 4, 1'($urandom),
           1'($urandom), $urandom % 64, 1'($urandom), 1'($urandom), 1'($urandom),
           "R2 R6 R8 mixed");

    // R1: reset mid-run clears config and flip-flop
    @(negedge clk); rst_n = 1'b0;
    #2;
    check("R1 async out", int'(elem_out), 0);
    m_tbl = '0; m_mode = 0; m_sel = 0; m_byp = 0; m_q = 0;
    @(negedge clk); rst_n = 1'b1;
    step(0, '0, 0, 0, 0, 7, 1, 0, 1, "R1 after reset");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule